// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Table Controller

This block holds the device-side state for message-signalled interrupts with a per-vector table (MSI-X style) in a PCI function. Software programs each vector through a 32-bit register window of 4 KiB. In that window, each vector has an address, a data word and a mask bit, and a packed pending-bit word can be read back. The function-level enable and mask-all bits arrive as plain inputs from the capability register, which lives elsewhere. Device logic raises one request pulse per vector. The block turns each request into a 64-bit-address / 32-bit-data message on a valid/ready output port, and a bus master that is not part of this block performs the write.

A request is dropped when its vector is outside the configured count or has a use count of zero. A request on a masked vector is latched as a pending bit. When the vector later becomes unmasked, the latched request is replayed without delay, whether the unmask came from its own mask bit, the mask-all bit or the enable bit. Sends that wait for the output port are queued one per vector and leave in ascending vector order.

Top module: `intmsg_table_ctrl`

## Requirements
- R1: Vector v occupies window offsets 16v to 16v+15, as four words. Word 0 is the low address, word 1 the high address, word 2 the message data, and word 3 is control with bit 0 as the vector's mask. A read returns the stored word. The window offset is bus_addr bits [11:2], so address bits [1:0] and bits above 11 are ignored.
- R2: A write is ignored when its offset is 0x800 or above, or when its entry index (offset / 16) is not below the configured count.
- R3: A read of offset 0x800 returns the pending bits, with bit v for vector v and zeros at and above the configured count. Every other word at 0x800 or above reads zero.
- R4: The configured count is taken from num_vec_i in the first cycle after reset ends. A value of 0 counts as 1, and a value above 32 counts as 32. After reset, all table words are zero except bit 0 of the control word of every configured vector, which is one. No message is valid, and no vector is pending or in use.
- R5: The function mask is active when cfg_enable_i is low or cfg_mask_all_i is high. A vector is masked when the function mask is active or its own mask bit is set.
- R6: A request on an unmasked, in-use vector, when nothing is queued and msg_ready_i is high, gives msg_valid_o high after the second rising edge following the request edge. The message carries address {high word, low word} and the data word.
- R7: A request on a masked, in-use vector sets its pending bit and sends no message.
- R8: When a pending vector changes from masked to unmasked, for any reason, its pending bit clears and its message is sent.
- R9: A request on a vector whose use count is zero, or whose index is not below the configured count, is dropped: no message is sent and no pending bit is set.
- R10: use_acq_i adds one to the use count of vector use_idx_i, and use_rel_i subtracts one without going below zero. Both are ignored for out-of-range indices. When a count falls to zero, that vector's pending bit and any queued send are cleared.
- R11: While msg_valid_o is high and msg_ready_i is low, the message and msg_vec_o hold steady. Each vector has at most one queued send, so repeated requests merge. Queued vectors leave in ascending index order.
- R12: A queued send whose vector becomes masked before it is presented becomes a pending bit instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| num_vec_i | input | 6 | Number of vectors to configure (static) |
| cfg_enable_i | input | 1 | Function enable bit from the capability register |
| cfg_mask_all_i | input | 1 | Function mask-all bit from the capability register |
| bus_addr_i | input | 32 | Register access byte address |
| bus_wr_i | input | 1 | Write strobe for one 32-bit word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| irq_req_i | input | 32 | Per-vector request pulses |
| use_acq_i | input | 1 | Increment use count of use_idx_i |
| use_rel_i | input | 1 | Decrement use count of use_idx_i |
| use_idx_i | input | 5 | Vector index for use count updates |
| msg_valid_o | output | 1 | Message available |
| msg_ready_i | input | 1 | Message taken by the consumer |
| msg_addr_o | output | 64 | Message target address |
| msg_data_o | output | 32 | Message data |
| msg_vec_o | output | 5 | Vector index of the message |

## Verification
The hardest state to reach from the ports is a vector with its send already queued behind a stalled output that then gets masked again, because this requires a queued send and a mask write to overlap. The bench holds msg_ready_i low so that one vector occupies the output register, then raises a second request so that it waits in the queue. It then sets that vector's mask bit and reads back offset 0x800 to see the queued send turn into a pending bit, before releasing the stall and unmasking. A second case lowers and raises mask-all while two vectors are pending, so that both replays begin in the same cycle and the ascending-order rule can be observed.

// File: rtl/intmsg_pkg.sv
package intmsg_pkg;
  localparam int WIN_AW       = 12;  // byte window of 4 KiB
  localparam int CTRL_MASK_BIT = 0;
  typedef enum logic [1:0] {
    SEL_ADDR_LO = 2'd0,
    SEL_ADDR_HI = 2'd1,
    SEL_DATA    = 2'd2,
    SEL_CTRL    = 2'd3
  } word_sel_e;
endpackage

// File: rtl/intmsg_table_store.sv
module intmsg_table_store import intmsg_pkg::*; #(
  parameter int MAX_VEC = 32,
  parameter int VEC_W   = 5,
  parameter int NV_W    = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init_i,
  input  logic [NV_W-1:0]    init_nv_i,
  input  logic               wr_en_i,
  input  logic [VEC_W-1:0]   wr_ent_i,
  input  logic [1:0]         wr_sel_i,
  input  logic [31:0]        wr_data_i,
  input  logic [VEC_W-1:0]   rd_ent_i,
  input  logic [1:0]         rd_sel_i,
  output logic [31:0]        rd_data_o,
  input  logic [VEC_W-1:0]   msg_ent_i,
  output logic [63:0]        msg_addr_o,
  output logic [31:0]        msg_data_o,
  output logic [MAX_VEC-1:0] vmask_o
);
  logic [31:0] lo_q [MAX_VEC];
  logic [31:0] hi_q [MAX_VEC];
  logic [31:0] dt_q [MAX_VEC];
  logic [31:0] ct_q [MAX_VEC];
  logic [31:0] lo_n [MAX_VEC];
  logic [31:0] hi_n [MAX_VEC];
  logic [31:0] dt_n [MAX_VEC];
  logic [31:0] ct_n [MAX_VEC];

  always_comb begin
    for (int e = 0; e < MAX_VEC; e++) begin
      lo_n[e] = lo_q[e];
      hi_n[e] = hi_q[e];
      dt_n[e] = dt_q[e];
      ct_n[e] = ct_q[e];
      if (init_i && (NV_W'(e) >= init_nv_i)) ct_n[e] = '0;
      if (wr_en_i && (wr_ent_i == VEC_W'(e))) begin
        case (word_sel_e'(wr_sel_i))
          SEL_ADDR_LO: lo_n[e] = wr_data_i;
          SEL_ADDR_HI: hi_n[e] = wr_data_i;
          SEL_DATA:    dt_n[e] = wr_data_i;
          default:     ct_n[e] = wr_data_i;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < MAX_VEC; e++) begin
        lo_q[e] <= '0;
        hi_q[e] <= '0;
        dt_q[e] <= '0;
        ct_q[e] <= 32'(1) << CTRL_MASK_BIT;
      end
    end else begin
      for (int e = 0; e < MAX_VEC; e++) begin
        lo_q[e] <= lo_n[e];
        hi_q[e] <= hi_n[e];
        dt_q[e] <= dt_n[e];
        ct_q[e] <= ct_n[e];
      end
    end
  end

  always_comb begin
    case (word_sel_e'(rd_sel_i))
      SEL_ADDR_LO: rd_data_o = lo_q[rd_ent_i];
      SEL_ADDR_HI: rd_data_o = hi_q[rd_ent_i];
      SEL_DATA:    rd_data_o = dt_q[rd_ent_i];
      default:     rd_data_o = ct_q[rd_ent_i];
    endcase
  end

  assign msg_addr_o = {hi_q[msg_ent_i], lo_q[msg_ent_i]};
  assign msg_data_o = dt_q[msg_ent_i];

  for (genvar e = 0; e < MAX_VEC; e++) begin : g_mask
    assign vmask_o[e] = ct_q[e][CTRL_MASK_BIT];
  end
endmodule

// File: rtl/intmsg_vec_state.sv
module intmsg_vec_state #(
  parameter int MAX_VEC = 32,
  parameter int VEC_W   = 5,
  parameter int NV_W    = 6,
  parameter int CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NV_W-1:0]    nv_i,
  input  logic               fmask_i,
  input  logic [MAX_VEC-1:0] vmask_i,
  input  logic [MAX_VEC-1:0] irq_i,
  input  logic               acq_i,
  input  logic               rel_i,
  input  logic [VEC_W-1:0]   idx_i,
  input  logic [MAX_VEC-1:0] grant_i,
  output logic [MAX_VEC-1:0] pend_o,
  output logic [MAX_VEC-1:0] send_o,
  output logic [MAX_VEC-1:0] cand_o,
  output logic [MAX_VEC-1:0] masked_o,
  output logic [MAX_VEC-1:0] masked_q_o
);
  for (genvar v = 0; v < MAX_VEC; v++) begin : g_vec
    localparam logic [NV_W-1:0]  VN = NV_W'(v);
    localparam logic [VEC_W-1:0] VI = VEC_W'(v);
    logic             pend_q, send_q, mskd_q;
    logic             pend_n, send_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             in_rng, hit, inc, dec, req_ok, unmask_evt, mskd_now;

    always_comb begin
      mskd_now   = fmask_i | vmask_i[v];
      in_rng     = VN < nv_i;
      hit        = in_rng && (idx_i == VI);
      inc        = acq_i && hit && (cnt_q != '1);
      dec        = rel_i && hit && (cnt_q != '0);
      cnt_n      = cnt_q;
      if (inc && !dec)      cnt_n = cnt_q + 1'b1;
      else if (dec && !inc) cnt_n = cnt_q - 1'b1;
      req_ok     = irq_i[v] && in_rng && (cnt_q != '0);
      unmask_evt = mskd_q && !mskd_now && pend_q;
      pend_n     = pend_q;
      send_n     = send_q;
      if (unmask_evt) begin
        pend_n = 1'b0;
        send_n = 1'b1;
      end
      if (send_q && mskd_now) begin
        send_n = 1'b0;
        pend_n = 1'b1;
      end
      if (grant_i[v]) send_n = 1'b0;
      if (req_ok) begin
        if (mskd_now) pend_n = 1'b1;
        else          send_n = 1'b1;
      end
      if ((cnt_q != '0) && (cnt_n == '0)) begin
        pend_n = 1'b0;
        send_n = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= 1'b0;
        send_q <= 1'b0;
        mskd_q <= 1'b1;
        cnt_q  <= '0;
      end else begin
        pend_q <= pend_n;
        send_q <= send_n;
        mskd_q <= mskd_now;
        if (inc != dec) cnt_q <= cnt_n;
      end
    end

    assign pend_o[v]     = pend_q;
    assign send_o[v]     = send_q;
    assign cand_o[v]     = send_q && !mskd_now;
    assign masked_o[v]   = mskd_now;
    assign masked_q_o[v] = mskd_q;
  end
endmodule

// File: rtl/intmsg_send_arb.sv
module intmsg_send_arb #(
  parameter int MAX_VEC = 32,
  parameter int VEC_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [MAX_VEC-1:0] cand_i,
  input  logic               ready_i,
  output logic [VEC_W-1:0]   pick_o,
  input  logic [63:0]        tbl_addr_i,
  input  logic [31:0]        tbl_data_i,
  output logic [MAX_VEC-1:0] grant_o,
  output logic               valid_o,
  output logic [63:0]        addr_o,
  output logic [31:0]        data_o,
  output logic [VEC_W-1:0]   vec_o
);
  logic             valid_q, valid_n, found, load;
  logic [VEC_W-1:0] pick, vec_q, vec_n;
  logic [63:0]      addr_q, addr_n;
  logic [31:0]      data_q, data_n;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = MAX_VEC - 1; i >= 0; i--) begin
      if (cand_i[i]) begin
        found = 1'b1;
        pick  = VEC_W'(i);
      end
    end
  end

  always_comb begin
    load    = !valid_q || ready_i;
    grant_o = (load && found) ? (MAX_VEC'(1) << pick) : '0;
    valid_n = found;
    vec_n   = found ? pick : vec_q;
    addr_n  = found ? tbl_addr_i : addr_q;
    data_n  = found ? tbl_data_i : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      vec_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (load) begin
      valid_q <= valid_n;
      vec_q   <= vec_n;
      addr_q  <= addr_n;
      data_q  <= data_n;
    end
  end

  assign pick_o  = pick;
  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign data_o  = data_q;
  assign vec_o   = vec_q;
endmodule

// File: rtl/intmsg_table_ctrl.sv
module intmsg_table_ctrl import intmsg_pkg::*; #(
  parameter  int MAX_VEC = 32,
  parameter  int CNT_W   = 4,
  localparam int VEC_W   = (MAX_VEC > 1) ? $clog2(MAX_VEC) : 1,
  localparam int NV_W    = VEC_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NV_W-1:0]    num_vec_i,
  input  logic               cfg_enable_i,
  input  logic               cfg_mask_all_i,
  input  logic [31:0]        bus_addr_i,
  input  logic               bus_wr_i,
  input  logic [31:0]        bus_wdata_i,
  output logic [31:0]        bus_rdata_o,
  input  logic [MAX_VEC-1:0] irq_req_i,
  input  logic               use_acq_i,
  input  logic               use_rel_i,
  input  logic [VEC_W-1:0]   use_idx_i,
  output logic               msg_valid_o,
  input  logic               msg_ready_i,
  output logic [63:0]        msg_addr_o,
  output logic [31:0]        msg_data_o,
  output logic [VEC_W-1:0]   msg_vec_o
);
  localparam int WO_W = WIN_AW - 2;

  logic              init_q;
  logic [NV_W-1:0]   nv_q, nv_clamp, nv_eff;
  logic [WO_W-1:0]   wo;
  logic              in_pend, wr_ok, rd_in_tbl;
  logic [WO_W-3:0]   ent;
  logic [7:0]        ent_ext;
  logic [31:0]       tbl_rdata;
  logic              fmask;
  logic [MAX_VEC-1:0] vmask, pend_vec, send_vec, cand, masked_now, masked_q, grant;
  logic [VEC_W-1:0]  pick;
  logic [63:0]       pick_addr;
  logic [31:0]       pick_data;
  logic              unused_bits;

  assign unused_bits = ^{bus_addr_i[31:WIN_AW], bus_addr_i[1:0]};

  // configured count capture in the first cycle after reset
  always_comb begin
    if (num_vec_i == '0)                    nv_clamp = NV_W'(1);
    else if (num_vec_i > NV_W'(MAX_VEC))    nv_clamp = NV_W'(MAX_VEC);
    else                                    nv_clamp = num_vec_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= 1'b1;
      nv_q   <= NV_W'(MAX_VEC);
    end else if (init_q) begin
      init_q <= 1'b0;
      nv_q   <= nv_clamp;
    end
  end

  assign nv_eff = init_q ? '0 : nv_q;
  assign fmask  = !cfg_enable_i || cfg_mask_all_i;

  // window decode: word offset wraps inside the 4 KiB window
  assign wo        = bus_addr_i[WIN_AW-1:2];
  assign in_pend   = wo[WO_W-1];
  assign ent       = wo[WO_W-2:2];
  assign ent_ext   = 8'(ent);
  assign wr_ok     = bus_wr_i && !in_pend && (ent_ext < 8'(nv_eff));
  assign rd_in_tbl = ent_ext < 8'(MAX_VEC);

  always_comb begin
    if (in_pend)        bus_rdata_o = (wo[WO_W-2:0] == '0) ? 32'(pend_vec) : '0;
    else if (rd_in_tbl) bus_rdata_o = tbl_rdata;
    else                bus_rdata_o = '0;
  end

  intmsg_table_store #(.MAX_VEC(MAX_VEC), .VEC_W(VEC_W), .NV_W(NV_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_i    (init_q),
    .init_nv_i (nv_clamp),
    .wr_en_i   (wr_ok),
    .wr_ent_i  (VEC_W'(ent)),
    .wr_sel_i  (wo[1:0]),
    .wr_data_i (bus_wdata_i),
    .rd_ent_i  (VEC_W'(ent)),
    .rd_sel_i  (wo[1:0]),
    .rd_data_o (tbl_rdata),
    .msg_ent_i (pick),
    .msg_addr_o(pick_addr),
    .msg_data_o(pick_data),
    .vmask_o   (vmask)
  );

  intmsg_vec_state #(.MAX_VEC(MAX_VEC), .VEC_W(VEC_W), .NV_W(NV_W), .CNT_W(CNT_W)) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .nv_i      (nv_eff),
    .fmask_i   (fmask),
    .vmask_i   (vmask),
    .irq_i     (irq_req_i),
    .acq_i     (use_acq_i),
    .rel_i     (use_rel_i),
    .idx_i     (use_idx_i),
    .grant_i   (grant),
    .pend_o    (pend_vec),
    .send_o    (send_vec),
    .cand_o    (cand),
    .masked_o  (masked_now),
    .masked_q_o(masked_q)
  );

  intmsg_send_arb #(.MAX_VEC(MAX_VEC), .VEC_W(VEC_W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .cand_i    (cand),
    .ready_i   (msg_ready_i),
    .pick_o    (pick),
    .tbl_addr_i(pick_addr),
    .tbl_data_i(pick_data),
    .grant_o   (grant),
    .valid_o   (msg_valid_o),
    .addr_o    (msg_addr_o),
    .data_o    (msg_data_o),
    .vec_o     (msg_vec_o)
  );
endmodule

// File: rtl/intmsg_table_ctrl_chk.sv
module intmsg_table_ctrl_chk #(
  parameter int MAX_VEC = 32,
  parameter int VEC_W   = 5,
  parameter int NV_W    = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               init_q,
  input logic [NV_W-1:0]    nv_q,
  input logic               msg_valid_o,
  input logic               msg_ready_i,
  input logic [63:0]        msg_addr_o,
  input logic [31:0]        msg_data_o,
  input logic [VEC_W-1:0]   msg_vec_o,
  input logic [MAX_VEC-1:0] pend_vec,
  input logic [MAX_VEC-1:0] send_vec,
  input logic [MAX_VEC-1:0] masked_now,
  input logic [MAX_VEC-1:0] masked_q,
  input logic [MAX_VEC-1:0] grant
);
  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid_o && !msg_ready_i |=> msg_valid_o && $stable(msg_vec_o) && $stable(msg_addr_o) && $stable(msg_data_o)); // R11
  AST_VEC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid_o |-> (NV_W'(msg_vec_o) < nv_q)); // R9
  AST_PEND_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !init_q |-> ((pend_vec >> nv_q) == '0)); // R3
  AST_PEND_SEND_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vec & send_vec) == '0); // R12
  AST_UNMASK_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    |(masked_q & ~masked_now & pend_vec) |=> ((pend_vec & $past(masked_q & ~masked_now & pend_vec)) == '0)); // R8
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & masked_now) == '0)); // R11
endmodule

bind intmsg_table_ctrl intmsg_table_ctrl_chk #(.MAX_VEC(MAX_VEC), .VEC_W(VEC_W), .NV_W(NV_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .init_q     (init_q),
  .nv_q       (nv_q),
  .msg_valid_o(msg_valid_o),
  .msg_ready_i(msg_ready_i),
  .msg_addr_o (msg_addr_o),
  .msg_data_o (msg_data_o),
  .msg_vec_o  (msg_vec_o),
  .pend_vec   (pend_vec),
  .send_vec   (send_vec),
  .masked_now (masked_now),
  .masked_q   (masked_q),
  .grant      (grant)
);

// File: tb/tb_intmsg_table_ctrl.sv
`timescale 1ns/1ps
module tb_intmsg_table_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  num_vec_i = 6'd6;
  logic        cfg_enable_i = 1'b0, cfg_mask_all_i = 1'b0;
  logic [31:0] bus_addr_i = '0, bus_wdata_i = '0;
  logic        bus_wr_i = 1'b0;
  logic [31:0] bus_rdata_o;
  logic [31:0] irq_req_i = '0;
  logic        use_acq_i = 1'b0, use_rel_i = 1'b0;
  logic [4:0]  use_idx_i = '0;
  logic        msg_valid_o;
  logic        msg_ready_i = 1'b1;
  logic [63:0] msg_addr_o;
  logic [31:0] msg_data_o;
  logic [4:0]  msg_vec_o;

  int checks = 0, errors = 0, msgcnt = 0, base = 0;
  logic [4:0]  log_vec  [64];
  logic [63:0] log_addr [64];
  logic [31:0] log_data [64];

  always #2 clk = ~clk;

  intmsg_table_ctrl dut (.*);

  always @(posedge clk) begin
    if (rst_n && msg_valid_o && msg_ready_i) begin
      log_vec[msgcnt % 64]  <= msg_vec_o;
      log_addr[msgcnt % 64] <= msg_addr_o;
      log_data[msgcnt % 64] <= msg_data_o;
      msgcnt <= msgcnt + 1;
    end
  end

  // write, read, expected-read for the table walk
  localparam int NTV = 9;
  localparam logic [127:0] TV [NTV] = '{
    {32'h000, 32'hA000_0000, 32'h000, 32'hA000_0000},
    {32'h004, 32'h0000_0000, 32'h004, 32'h0000_0000},
    {32'h008, 32'h0000_0100, 32'h008, 32'h0000_0100},
    {32'h013, 32'h1234_5670, 32'h010, 32'h1234_5670},
    {32'h1014, 32'h0000_0001, 32'h014, 32'h0000_0001},
    {32'h018, 32'hCAFE_0018, 32'hF018, 32'hCAFE_0018},
    {32'h060, 32'hDEAD_BEEF, 32'h060, 32'h0000_0000},
    {32'h800, 32'hFFFF_FFFF, 32'h800, 32'h0000_0000},
    {32'h0C0, 32'h5555_AAAA, 32'h0C0, 32'h0000_0000}
  };

  function automatic logic [63:0] exp_addr(int v);
    return {32'(v), 32'hA000_0000 + 32'(16 * v)};
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
    @(negedge clk);
    bus_wr_i = 1'b0;
  endtask

  task automatic rd(logic [31:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_addr_i = a;
    #1;
    check(tag, 64'(bus_rdata_o), 64'(exp));
  endtask

  task automatic pulse(logic [31:0] m);
    @(negedge clk);
    irq_req_i = m;
    @(negedge clk);
    irq_req_i = '0;
  endtask

  task automatic use_op(bit acq, bit rel, int idx);
    @(negedge clk);
    use_acq_i = acq; use_rel_i = rel; use_idx_i = 5'(idx);
    @(negedge clk);
    use_acq_i = 1'b0; use_rel_i = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic do_reset(logic [5:0] n);
    @(negedge clk);
    rst_n = 1'b0; num_vec_i = n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_msg(int k, int v, string tag);
    check({tag, " vec"},  64'(log_vec[k % 64]), 64'(v));
    check({tag, " addr"}, log_addr[k % 64], exp_addr(v));
    check({tag, " data"}, 64'(log_data[k % 64]), 64'(32'h100 + v));
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    do_reset(6'd6);
    // R4: reset state
    check("R4 valid after reset", 64'(msg_valid_o), 64'd0);
    rd(32'h00C, 32'h1, "R4 ctrl v0");
    rd(32'h05C, 32'h1, "R4 ctrl v5");
    rd(32'h06C, 32'h0, "R4 ctrl v6 unconfigured");
    rd(32'h004, 32'h0, "R4 addr word zero");
    rd(32'h800, 32'h0, "R4 pending zero");

    // table walk: R1 layout and wrap, R2 ignored writes
    for (int i = 0; i < NTV; i++) begin
      wr(TV[i][127:96], TV[i][95:64]);
      rd(TV[i][63:32], TV[i][31:0], "R1 or R2 table word");
    end

    for (int v = 0; v < 6; v++) begin
      wr(32'(16 * v),     exp_addr(v)[31:0]);
      wr(32'(16 * v + 4), exp_addr(v)[63:32]);
      wr(32'(16 * v + 8), 32'h100 + 32'(v));
    end
    cfg_enable_i = 1'b1;
    for (int v = 0; v < 4; v++) use_op(1'b1, 1'b0, v);

    // R7: masked request latches
    base = msgcnt;
    pulse(32'h2); settle();
    check("R7 no message while masked", 64'(msgcnt), 64'(base));
    rd(32'h800, 32'h2, "R7 pending bit v1");

    // R8: per-vector unmask replays
    wr(32'h01C, 32'h0); settle();
    check("R8 replay count", 64'(msgcnt), 64'(base + 1));
    chk_msg(base, 1, "R8 replay");
    rd(32'h800, 32'h0, "R8 pending cleared");

    // R6: latency of a direct send
    base = msgcnt;
    pulse(32'h2);
    @(negedge clk);
    check("R6 valid two edges after request", 64'(msg_valid_o), 64'd1);
    check("R6 vector", 64'(msg_vec_o), 64'd1);
    settle();
    chk_msg(base, 1, "R6 message");

    // R9: unused and out-of-range vectors dropped
    wr(32'h04C, 32'h0);
    base = msgcnt;
    pulse(32'h10); pulse(32'h80); settle();
    check("R9 no message", 64'(msgcnt), 64'(base));
    rd(32'h800, 32'h0, "R9 no pending");

    // R5 and R8: mask-all holds, release replays in ascending order
    wr(32'h00C, 32'h0); wr(32'h02C, 32'h0); wr(32'h03C, 32'h0);
    @(negedge clk); cfg_mask_all_i = 1'b1;
    base = msgcnt;
    pulse(32'h9); settle();
    check("R5 mask-all blocks", 64'(msgcnt), 64'(base));
    rd(32'h800, 32'h9, "R5 pending under mask-all");
    @(negedge clk); cfg_mask_all_i = 1'b0;
    settle();
    check("R8 function unmask count", 64'(msgcnt), 64'(base + 2));
    chk_msg(base, 0, "R11 first");
    chk_msg(base + 1, 3, "R11 second");

    // R5: disabled function masks
    @(negedge clk); cfg_enable_i = 1'b0;
    base = msgcnt;
    pulse(32'h4); settle();
    rd(32'h800, 32'h4, "R5 pending while disabled");
    check("R5 no message while disabled", 64'(msgcnt), 64'(base));
    @(negedge clk); cfg_enable_i = 1'b1;
    settle();
    chk_msg(base, 2, "R5 enable replay");

    // R11: stall, merge and ascending order
    @(negedge clk); msg_ready_i = 1'b0;
    base = msgcnt;
    pulse(32'h8);
    @(negedge clk);
    check("R11 presented", 64'(msg_vec_o), 64'd3);
    pulse(32'h5); pulse(32'h4);
    repeat (4) @(negedge clk);
    check("R11 held valid", 64'(msg_valid_o), 64'd1);
    check("R11 held vec", 64'(msg_vec_o), 64'd3);
    check("R11 held addr", msg_addr_o, exp_addr(3));
    msg_ready_i = 1'b1;
    settle();
    check("R11 merged count", 64'(msgcnt), 64'(base + 3));
    chk_msg(base, 3, "R11 order a");
    chk_msg(base + 1, 0, "R11 order b");
    chk_msg(base + 2, 2, "R11 order c");

    // R12: queued send masked again
    @(negedge clk); msg_ready_i = 1'b0;
    base = msgcnt;
    pulse(32'h2); pulse(32'h4);
    repeat (2) @(negedge clk);
    wr(32'h02C, 32'h1);
    repeat (3) @(negedge clk);
    rd(32'h800, 32'h4, "R12 queued becomes pending");
    msg_ready_i = 1'b1;
    settle();
    check("R12 only presented sent", 64'(msgcnt), 64'(base + 1));
    chk_msg(base, 1, "R12 presented");
    wr(32'h02C, 32'h0); settle();
    check("R12 replay count", 64'(msgcnt), 64'(base + 2));
    chk_msg(base + 1, 2, "R12 replay");

    // R10: use count release clears pending
    @(negedge clk); cfg_mask_all_i = 1'b1;
    pulse(32'h1); settle();
    rd(32'h800, 32'h1, "R10 pending before release");
    use_op(1'b0, 1'b1, 0);
    rd(32'h800, 32'h0, "R10 release clears pending");
    @(negedge clk); cfg_mask_all_i = 1'b0;
    base = msgcnt;
    settle();
    pulse(32'h1); settle();
    check("R10 unused vector silent", 64'(msgcnt), 64'(base));
    use_op(1'b1, 1'b0, 1); use_op(1'b0, 1'b1, 1);
    pulse(32'h2); settle();
    check("R10 count still nonzero", 64'(msgcnt), 64'(base + 1));

    // R4: clamped counts
    do_reset(6'd0);
    rd(32'h00C, 32'h1, "R4 count zero gives one");
    rd(32'h01C, 32'h0, "R4 v1 unconfigured");
    rd(32'h000, 32'h0, "R4 table zeroed");
    wr(32'h010, 32'h77);
    rd(32'h010, 32'h0, "R2 entry beyond count");
    check("R4 no message", 64'(msg_valid_o), 64'd0);
    do_reset(6'd40);
    rd(32'h1FC, 32'h1, "R4 clamp to 32");
    rd(32'h800, 32'h0, "R4 pending after reset");

    finish_run();
  end
endmodule